// File: doc/BRIEF.md
# Space-Vector Sector and Dwell-Time Calculator

This block serves the modulator of a three-phase, two-level inverter. Once per switching period it takes a held reference vector, given as a signed angle and a normalized magnitude (the modulation index). It reports which of the six 60-degree sectors of the hexagon the vector falls in. It also reports how many clock ticks the two adjacent active vectors (T1, T2) and the zero vectors (T0) must be applied so that their time average equals the reference. A downstream sequencer turns these counts into gate pulses. The polar reference itself comes from an upstream coordinate transform.

The angle uses 1/`UNITS_PER_DEG` degree per LSB and covers −180° to +180°. Every sector is folded onto the first one by subtracting or adding a fixed multiple of 60°. One pair of dwell equations, driven by an elaboration-time table that holds √3·sin over 0°–60°, therefore serves all six sectors. If the two active times together would exceed the period, they are shrunk in proportion by a bit-serial divider, and T0 is pinned to zero. The divider always runs for the same number of cycles, so the latency is fixed.

A state machine sequences the work. In IDLE it waits for a strobe. It then passes through ROTATE (sector and in-sector angle), LOOKUP (table reads), SCALE (raw products and divider set-up), DIVIDE (one quotient bit per cycle) and EMIT (outputs and valid). The transitions are: IDLE→ROTATE on a strobe, then ROTATE→LOOKUP→SCALE→DIVIDE unconditionally, DIVIDE→EMIT once the last quotient bit is taken, and EMIT→IDLE.

Top module: `svm_dwell_calc`

## Requirements
- R1: `sector_o` is 1 for angles in [0°,60°), 2 for [60°,120°), 3 for [120°,180°), 6 for [−60°,0°), 5 for [−120°,−60°) and 4 for [−180°,−120°). An angle on a boundary goes to the sector above it, and +180° is handled exactly as −180°.
- R2: The in-sector angle θ is the input angle minus 0°, 60° or 120° in sectors 1–3, and plus 60°, 120° or 180° in sectors 6, 5 and 4. In the linear region, `t1_o` is within 2 ticks of √3·m·Ts·sin(60°−θ), where m = `mod_index`/2^MAG_W and Ts = `PERIOD`.
- R3: In the linear region, `t2_o` is within 2 ticks of √3·m·Ts·sin(θ).
- R4: When the unscaled T1+T2 does not exceed Ts, `t0_o` equals Ts − `t1_o` − `t2_o` exactly. A zero modulation index gives T1 = T2 = 0 and T0 = Ts.
- R5: When the unscaled T1+T2 exceeds Ts, `t0_o` is 0, `t1_o`+`t2_o` equals Ts, and `t1_o` is within 2 ticks of Ts·T1/(T1+T2).
- R6: `valid_o` is a one-cycle pulse. It goes high exactly 2·⌈log2(Ts+1)⌉+5 rising edges after the edge that samples `sample_stb` high in IDLE (23 for Ts = 500).
- R7: `sector_o`, `t1_o`, `t2_o` and `t0_o` change only on the cycle in which `valid_o` is high. At all other times they hold their values.
- R8: A strobe that arrives while a calculation is under way has no effect. The result that follows belongs to the sample that started the calculation.
- R9: While `rst_n` is low, every output is zero and `valid_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | Start of a new switching period; the inputs are captured when idle |
| angle | input | ANG_W | Signed reference angle, 1/UNITS_PER_DEG degree per LSB |
| mod_index | input | MAG_W | Modulation index, unsigned fraction of 2^MAG_W |
| sector_o | output | 3 | Sector number 1..6 |
| t1_o | output | TW | Dwell of the first active vector, in ticks |
| t2_o | output | TW | Dwell of the second active vector, in ticks |
| t0_o | output | TW | Dwell of the zero vectors, in ticks |
| valid_o | output | 1 | One-cycle pulse when new results are presented |

## Verification
The stimulus places angles on each sector boundary, one LSB below a boundary, at exactly ±180°, and inside sectors. A fold that picks the wrong side of a boundary shows up as a wrong sector number or a T1/T2 swap. A fold that treats +180° as a sector of its own reports a sector outside 1..6. Magnitudes cover zero, the linear region and deep overmodulation. A missing clamp would give a T0 that wraps or active times that overrun the period. A scaler that is off would break the proportion between T1 and T2. A strobe fired mid-calculation catches a controller that restarts, which would move the valid pulse and replace the result. Valid timing and output hold are compared against the reference model on every clock.

// File: rtl/svm_pkg.sv
package svm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ROTATE,
        ST_LOOKUP,
        ST_SCALE,
        ST_DIVIDE,
        ST_EMIT
    } svm_state_e;

endpackage

// File: rtl/svm_sector_fold.sv
// Maps a signed angle onto a sector number and the angle inside that sector.
module svm_sector_fold #(
    parameter int ANG_W         = 12,
    parameter int UNITS_PER_DEG = 4,
    parameter int LOC_W         = $clog2(60 * UNITS_PER_DEG + 1)
) (
    input  logic signed [ANG_W-1:0] angle,
    output logic [2:0]              sector,
    output logic [LOC_W-1:0]        local_ang
);
    localparam int U60 = 60 * UNITS_PER_DEG;

    int a;
    int loc;

    always_comb begin
        a = int'(angle);
        if (a == 3 * U60) a = -3 * U60;   // +180 folds onto -180
        if (a >= 2 * U60) begin
            sector = 3'd3; loc = a - 2 * U60;
        end else if (a >= U60) begin
            sector = 3'd2; loc = a - U60;
        end else if (a >= 0) begin
            sector = 3'd1; loc = a;
        end else if (a >= -U60) begin
            sector = 3'd6; loc = a + U60;
        end else if (a >= -2 * U60) begin
            sector = 3'd5; loc = a + 2 * U60;
        end else begin
            sector = 3'd4; loc = a + 3 * U60;
        end
        local_ang = LOC_W'(loc);
    end

endmodule

// File: rtl/svm_sine_rom.sv
// Two read ports into a table of round(sqrt(3) * sin(x) * 2^SIN_FRAC), x over 0..60 degrees.
module svm_sine_rom #(
    parameter int UNITS_PER_DEG = 4,
    parameter int LOC_W         = $clog2(60 * UNITS_PER_DEG + 1),
    parameter int TBL_W         = 16,
    parameter int SIN_FRAC      = 14
) (
    input  logic [LOC_W-1:0] idx_a,
    input  logic [LOC_W-1:0] idx_b,
    output logic [TBL_W-1:0] val_a,
    output logic [TBL_W-1:0] val_b
);
    localparam int U60 = 60 * UNITS_PER_DEG;

    logic [TBL_W-1:0] tbl [0:U60];

    for (genvar i = 0; i <= U60; i++) begin : g_ent
        localparam real RAD = 3.141592653589793 * i / (3.0 * U60);
        localparam real VAL = 1.7320508075688772 * $sin(RAD) * (2.0 ** SIN_FRAC);
        assign tbl[i] = TBL_W'($rtoi(VAL + 0.5));
    end

    always_comb begin
        val_a = (int'(idx_a) <= U60) ? tbl[idx_a] : '0;
        val_b = (int'(idx_b) <= U60) ? tbl[idx_b] : '0;
    end

endmodule

// File: rtl/svm_dwell_calc.sv
module svm_dwell_calc
    import svm_pkg::*;
#(
    parameter int ANG_W         = 12,
    parameter int MAG_W         = 10,
    parameter int UNITS_PER_DEG = 4,
    parameter int PERIOD        = 500,
    localparam int TW           = $clog2(PERIOD + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sample_stb,
    input  logic signed [ANG_W-1:0] angle,
    input  logic [MAG_W-1:0]        mod_index,
    output logic [2:0]              sector_o,
    output logic [TW-1:0]           t1_o,
    output logic [TW-1:0]           t2_o,
    output logic [TW-1:0]           t0_o,
    output logic                    valid_o
);
    localparam int U60      = 60 * UNITS_PER_DEG;
    localparam int LOC_W    = $clog2(U60 + 1);
    localparam int TBL_W    = 16;
    localparam int SIN_FRAC = 14;
    localparam int SHIFT    = MAG_W + SIN_FRAC;
    localparam int RAW_W    = TW + 1;            // unscaled dwell can reach ~1.5 Ts
    localparam int SUM_W    = RAW_W + 1;
    localparam int NUM_W    = RAW_W + TW;        // T1 * Ts
    localparam int DEN_W    = SUM_W;
    localparam int PROD_W   = TW + MAG_W + TBL_W;
    localparam int CNT_W    = $clog2(NUM_W + 1);
    localparam int WIDE_W   = TW + 2;

    svm_state_e state_q, state_d;

    logic signed [ANG_W-1:0] ang_q;
    logic [MAG_W-1:0]        mag_q;
    logic [2:0]              sec_c, sec_q;
    logic [LOC_W-1:0]        loc_c, loc_q;
    logic [TBL_W-1:0]        sin_a_c, sin_b_c, sin_a_q, sin_b_q;
    logic [PROD_W-1:0]       prod_a, prod_b;
    logic [RAW_W-1:0]        t1_c, t2_c, t1_raw_q, t2_raw_q;
    logic [SUM_W-1:0]        sum_c;
    logic                    over_c, over_q;
    logic [NUM_W-1:0]        num_q;
    logic [DEN_W-1:0]        den_q, rem_q;
    logic [DEN_W:0]          trial;
    logic [TW-1:0]           quo_q;
    logic [CNT_W-1:0]        cnt_q;
    logic [WIDE_W-1:0]       t0_lin;

    svm_sector_fold #(
        .ANG_W(ANG_W), .UNITS_PER_DEG(UNITS_PER_DEG), .LOC_W(LOC_W)
    ) u_fold (
        .angle(ang_q), .sector(sec_c), .local_ang(loc_c)
    );

    svm_sine_rom #(
        .UNITS_PER_DEG(UNITS_PER_DEG), .LOC_W(LOC_W),
        .TBL_W(TBL_W), .SIN_FRAC(SIN_FRAC)
    ) u_rom (
        .idx_a(LOC_W'(U60) - loc_q), .idx_b(loc_q),
        .val_a(sin_a_c), .val_b(sin_b_c)
    );

    // Dwell arithmetic shared by every sector
    always_comb begin
        prod_a = PROD_W'(PERIOD) * PROD_W'(mag_q) * PROD_W'(sin_a_q);
        prod_b = PROD_W'(PERIOD) * PROD_W'(mag_q) * PROD_W'(sin_b_q);
        t1_c   = RAW_W'(prod_a >> SHIFT);
        t2_c   = RAW_W'(prod_b >> SHIFT);
        sum_c  = SUM_W'(t1_c) + SUM_W'(t2_c);
        over_c = sum_c > SUM_W'(PERIOD);
        trial  = {rem_q, num_q[NUM_W-1]};
        t0_lin = WIDE_W'(PERIOD) - WIDE_W'(t1_raw_q) - WIDE_W'(t2_raw_q);
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sample_stb) state_d = ST_ROTATE;
            ST_ROTATE: state_d = ST_LOOKUP;
            ST_LOOKUP: state_d = ST_SCALE;
            ST_SCALE:  state_d = ST_DIVIDE;
            ST_DIVIDE: if (cnt_q == CNT_W'(NUM_W - 1)) state_d = ST_EMIT;
            ST_EMIT:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Datapath and outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ang_q    <= '0;  mag_q    <= '0;
            sec_q    <= '0;  loc_q    <= '0;
            sin_a_q  <= '0;  sin_b_q  <= '0;
            t1_raw_q <= '0;  t2_raw_q <= '0;
            over_q   <= 1'b0;
            num_q    <= '0;  den_q    <= '0;
            rem_q    <= '0;  quo_q    <= '0;
            cnt_q    <= '0;
            sector_o <= '0;
            t1_o     <= '0;  t2_o     <= '0;  t0_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (sample_stb) begin
                        ang_q <= angle;
                        mag_q <= mod_index;
                    end
                end
                ST_ROTATE: begin
                    sec_q <= sec_c;
                    loc_q <= loc_c;
                end
                ST_LOOKUP: begin
                    sin_a_q <= sin_a_c;
                    sin_b_q <= sin_b_c;
                end
                ST_SCALE: begin
                    t1_raw_q <= t1_c;
                    t2_raw_q <= t2_c;
                    over_q   <= over_c;
                    num_q    <= NUM_W'(t1_c) * NUM_W'(PERIOD);
                    den_q    <= over_c ? DEN_W'(sum_c) : DEN_W'(PERIOD);
                    rem_q    <= '0;
                    quo_q    <= '0;
                    cnt_q    <= '0;
                end
                ST_DIVIDE: begin
                    num_q <= num_q << 1;
                    cnt_q <= cnt_q + 1'b1;
                    if (trial >= {1'b0, den_q}) begin
                        rem_q <= DEN_W'(trial - {1'b0, den_q});
                        quo_q <= {quo_q[TW-2:0], 1'b1};
                    end else begin
                        rem_q <= DEN_W'(trial);
                        quo_q <= {quo_q[TW-2:0], 1'b0};
                    end
                end
                ST_EMIT: begin
                    sector_o <= sec_q;
                    t1_o     <= quo_q;
                    t2_o     <= over_q ? TW'(PERIOD) - quo_q : TW'(t2_raw_q);
                    t0_o     <= over_q ? '0 : TW'(t0_lin);
                    valid_o  <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/svm_dwell_calc_chk.sv
module svm_dwell_calc_chk #(
    parameter int PERIOD = 500,
    parameter int TW     = $clog2(PERIOD + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [2:0]    sector_o,
    input logic [TW-1:0] t1_o,
    input logic [TW-1:0] t2_o,
    input logic [TW-1:0] t0_o,
    input logic          valid_o
);
    p_sector_range_r1: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (sector_o >= 3'd1 && sector_o <= 3'd6));

    p_period_split_r4: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (int'(t1_o) + int'(t2_o) + int'(t0_o) == PERIOD));

    p_active_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (int'(t1_o) <= PERIOD && int'(t2_o) <= PERIOD));

    p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |=> !valid_o);

    p_hold_outputs_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> $stable({sector_o, t1_o, t2_o, t0_o}));

endmodule

bind svm_dwell_calc svm_dwell_calc_chk #(.PERIOD(PERIOD), .TW(TW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sector_o(sector_o),
    .t1_o(t1_o), .t2_o(t2_o), .t0_o(t0_o), .valid_o(valid_o)
);

// File: tb/svm_dwell_calc_bench.sv
module svm_dwell_calc_bench;
    localparam int ANG_W = 12;
    localparam int MAG_W = 10;
    localparam int UPD   = 4;
    localparam int TS    = 500;
    localparam int TW    = $clog2(TS + 1);
    localparam int LAT   = 2 * TW + 5;
    localparam real PI   = 3.141592653589793;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sample_stb = 1'b0;
    logic signed [ANG_W-1:0] angle = '0;
    logic [MAG_W-1:0] mod_index = '0;
    logic [2:0] sector_o;
    logic [TW-1:0] t1_o, t2_o, t0_o;
    logic valid_o;

    always #2 clk = ~clk;   // 250 MHz

    svm_dwell_calc #(.ANG_W(ANG_W), .MAG_W(MAG_W), .UNITS_PER_DEG(UPD), .PERIOD(TS))
    u_svm_dwell_calc (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .angle(angle),
        .mod_index(mod_index), .sector_o(sector_o), .t1_o(t1_o), .t2_o(t2_o),
        .t0_o(t0_o), .valid_o(valid_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    int  cnt = 0;
    bit  exp_valid = 0;
    int  pend_a = 0, pend_m = 0;
    int  hold_s = 0, hold_1 = 0, hold_2 = 0, hold_0 = 0;

    // expected values for one sample
    int  e_sec;
    real e_t1, e_t2, e_t0;
    bit  e_over;

    task automatic model(input int a, input int m);
        real deg, loc, mr;
        if (a == 180 * UPD) a = -180 * UPD;
        deg = real'(a) / UPD;
        if (deg >= 120.0)      begin e_sec = 3; loc = deg - 120.0; end
        else if (deg >= 60.0)  begin e_sec = 2; loc = deg - 60.0;  end
        else if (deg >= 0.0)   begin e_sec = 1; loc = deg;         end
        else if (deg >= -60.0) begin e_sec = 6; loc = deg + 60.0;  end
        else if (deg >= -120.0) begin e_sec = 5; loc = deg + 120.0; end
        else                   begin e_sec = 4; loc = deg + 180.0; end
        mr   = real'(m) / (2.0 ** MAG_W);
        e_t1 = $sqrt(3.0) * mr * TS * $sin((60.0 - loc) * PI / 180.0);
        e_t2 = $sqrt(3.0) * mr * TS * $sin(loc * PI / 180.0);
        e_over = (e_t1 + e_t2) > TS;
        if (e_over) begin
            e_t1 = e_t1 * TS / (e_t1 + e_t2);
            e_t2 = TS - e_t1;
            e_t0 = 0.0;
        end else begin
            e_t0 = TS - e_t1 - e_t2;
        end
    endtask

    task automatic chk_eq(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic chk_near(input string tag, input int act, input real exp);
        real d;
        n_cmp++;
        d = real'(act) - exp;
        if (d > 2.0 || d < -2.0) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0.2f", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    // reference timing: when the block accepts a strobe and when valid is due
    always @(posedge clk) begin
        if (!rst_n) begin
            cnt = 0; exp_valid = 0;
        end else begin
            exp_valid = 0;
            if (cnt > 0) begin
                cnt = cnt - 1;
                if (cnt == 0) exp_valid = 1;
            end else if (sample_stb) begin
                cnt = LAT;
                pend_a = int'(angle);
                pend_m = int'(mod_index);
            end
        end
    end

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk_eq("R6 valid timing", int'(valid_o), int'(exp_valid));
            if (exp_valid) begin
                model(pend_a, pend_m);
                chk_eq("R1 sector", int'(sector_o), e_sec);
                if (e_over) begin
                    chk_near("R5 scaled t1", int'(t1_o), e_t1);
                    chk_eq("R5 t0 clamp", int'(t0_o), 0);
                    chk_eq("R5 t1+t2", int'(t1_o) + int'(t2_o), TS);
                end else begin
                    chk_near("R2 t1", int'(t1_o), e_t1);
                    chk_near("R3 t2", int'(t2_o), e_t2);
                    chk_eq("R4 t0", int'(t0_o), TS - int'(t1_o) - int'(t2_o));
                end
                hold_s = int'(sector_o); hold_1 = int'(t1_o);
                hold_2 = int'(t2_o);     hold_0 = int'(t0_o);
            end else begin
                chk_eq("R7 hold sector", int'(sector_o), hold_s);
                chk_eq("R7 hold t1", int'(t1_o), hold_1);
                chk_eq("R7 hold t2", int'(t2_o), hold_2);
                chk_eq("R7 hold t0", int'(t0_o), hold_0);
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            n_cmp++; n_bad++;
            $display("FAIL R6 watchdog actual=%0d cycles expected=completion", cyc);
            summary();
        end
    end

    task automatic sample(input int a, input int m);
        @(negedge clk);
        angle = ANG_W'(a); mod_index = MAG_W'(m); sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        repeat (LAT + 2) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R9: reset state
        chk_eq("R9 reset valid", int'(valid_o), 0);
        chk_eq("R9 reset sector", int'(sector_o), 0);
        chk_eq("R9 reset t1", int'(t1_o), 0);
        chk_eq("R9 reset t0", int'(t0_o), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1/R2/R3/R4: linear region, sector interiors and boundaries
        sample(0, 400);
        sample(100, 400);
        sample(239, 400);
        sample(240, 400);
        sample(479, 500);
        sample(480, 500);
        sample(600, 300);
        sample(720, 400);    // +180 handled as -180
        sample(-720, 400);
        sample(-600, 450);
        sample(-480, 400);
        sample(-241, 400);
        sample(-240, 400);
        sample(-1, 400);
        // R4: zero modulation index
        sample(333, 0);
        chk_eq("R4 zero index t0", int'(t0_o), TS);
        // R5: overmodulation
        sample(0, 1000);
        sample(120, 1023);
        sample(-350, 900);
        sample(700, 1010);

        // R8: strobe during a calculation is ignored
        @(negedge clk);
        angle = ANG_W'(100); mod_index = MAG_W'(400); sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        repeat (3) @(negedge clk);
        angle = ANG_W'(-300); mod_index = MAG_W'(800); sample_stb = 1'b1;
        @(negedge clk);
        sample_stb = 1'b0;
        repeat (LAT + 2) @(negedge clk);
        chk_eq("R8 ignored strobe sector", int'(sector_o), 1);
        repeat (LAT + 4) @(negedge clk);
        chk_eq("R8 no second result valid", int'(valid_o), 0);
        chk_eq("R8 result kept", int'(sector_o), 1);

        summary();
    end
endmodule